// File: doc/BRIEF.md
# Interleaving Vector Store Datapath

This block holds a small vector register file and turns one part of an interleaved vector store into two 64-bit memory write beats. A store is split into parts of 128 bits each. Two-way interleave takes two parts and four-way interleave takes four. Each part names a starting vector register, and the stream uses that register and the next one or three registers, wrapping from the last register to the first. Element sizes of 8, 16 and 32 bits are supported. A part always writes one contiguous, 16-byte aligned block as two 8-byte beats whose addresses differ only in bit 3, so the two beats can go to separate 64-bit banks.

The register file holds eight 128-bit registers, each made of four 32-bit words. Four independent read ports each pick one register and one word of it. A byte crossbar then places the fetched bytes in memory order. The mapping follows one rule. Memory element k of the interleaved stream is lane k div F of register (start + k mod F) mod 8, where F is the interleave factor, and part p covers stream bytes 16p to 16p+15. A small state machine has the states IDLE, LO_BEAT and HI_BEAT. On an accepted start it moves IDLE to LO_BEAT. It always moves LO_BEAT to HI_BEAT and HI_BEAT to IDLE. A rejected start leaves it in IDLE and pulses the error flag.

Top module: `ilv_store_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, `beat_valid` and `st_err` are 0. Reset clears every register to zero.
- R2: When `reg_wr_en` is 1 at a rising edge, register `reg_wr_idx` takes `reg_wr_data`. Register byte b is bits [8b+7:8b]. A store started in that same cycle already reads the new value.
- R3: An accepted start makes `beat_valid` 1 for exactly two consecutive cycles, beginning in the cycle after the start edge. It is then 0.
- R4: The first beat carries address base + 16*part and the second carries base + 16*part + 8. Bit 3 is 0 on the first beat and 1 on the second, and all higher bits are equal.
- R5: In four-way mode (`st_four`=1, part 0..3), byte i of a beat is memory byte addr+i. Its value is the register byte given by the mapping rule, for element size codes 0 (8 bit), 1 (16 bit) and 2 (32 bit).
- R6: Two-way mode (`st_four`=0, part 0..1) follows the same rule with F=2 for all three element sizes.
- R7: The registers used are (`st_qbase` + j) mod 8, so a start register near the top wraps around to register 0.
- R8: A start whose base has any of bits [3:0] set gives no beats. Instead `st_err` is 1 for exactly the next cycle.
- R9: A start with size code 3, or with part 2 or 3 in two-way mode, gives no beats. Instead `st_err` is 1 for exactly the next cycle.
- R10: A start that arrives while a store is in progress (in the cycles where `beat_valid` is 1) is ignored. It raises no error and does not change or extend the beats.
- R11: `beat_data` and `beat_addr` are 0 whenever `beat_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr_en | input | 1 | Write strobe for the register file |
| reg_wr_idx | input | 3 | Register to write |
| reg_wr_data | input | 128 | Register write value |
| st_start | input | 1 | Start one store part |
| st_part | input | 2 | Part index within the interleaved store |
| st_four | input | 1 | 1 = four-way interleave, 0 = two-way |
| st_size | input | 2 | Element size: 0 = 8, 1 = 16, 2 = 32 bit |
| st_qbase | input | 3 | First register of the interleaved group |
| st_base | input | 32 | Byte base address of the whole store |
| beat_valid | output | 1 | A write beat is present |
| beat_addr | output | 32 | Byte address of the beat |
| beat_data | output | 64 | Beat data, byte i at address beat_addr+i |
| st_err | output | 1 | One-cycle pulse for a rejected start |

## Verification
A wrong port word select or crossbar select shows up as a wrong byte on `beat_data` in the very beat that uses it. Only particular factor, size and part combinations expose a given mistake, so every combination is run with random register contents and a fresh start register. A sequencer stuck in or skipping a state shows on `beat_valid` or on address bit 3 within one cycle of the start. A wrongly decoded command shows as a missing or extra `st_err` pulse one cycle after the start. The reference model predicts all outputs for every cycle, so any divergence is reported in the cycle where it first appears.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LO_BEAT = 2'd1,
        ST_HI_BEAT = 2'd2
    } ilv_state_t;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned SIZE_B8  = 0;
    localparam int unsigned SIZE_B16 = 1;
    localparam int unsigned SIZE_B32 = 2;
endpackage

// File: rtl/ilv_regfile.sv
module ilv_regfile #(
    parameter int unsigned NREG  = 8,
    parameter int unsigned VBITS = 128,
    parameter int unsigned WBITS = 32,
    localparam int unsigned WORDS = VBITS / WBITS,
    localparam int unsigned RAW   = $clog2(NREG),
    localparam int unsigned WAW   = $clog2(WORDS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [RAW-1:0]              wr_idx,
    input  logic [VBITS-1:0]            wr_data,
    input  logic [WORDS-1:0][RAW-1:0]   rd_reg,
    input  logic [WORDS-1:0][WAW-1:0]   rd_word,
    output logic [WORDS-1:0][WBITS-1:0] rd_data
);
    logic [VBITS-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREG; r++) begin
                regs[r] <= '0;
            end
        end else if (wr_en) begin
            regs[wr_idx] <= wr_data;
        end
    end

    // one read port per word column, each with its own register and word select
    for (genvar j = 0; j < WORDS; j++) begin : g_port
        logic [VBITS-1:0] row;
        assign row        = regs[rd_reg[j]];
        assign rd_data[j] = row[rd_word[j]*WBITS +: WBITS];
    end
endmodule

// File: rtl/ilv_xbar.sv
module ilv_xbar #(
    parameter int unsigned IN_BYTES  = 16,
    parameter int unsigned OUT_BYTES = 8,
    localparam int unsigned SW = $clog2(IN_BYTES)
) (
    input  logic [IN_BYTES*8-1:0]          src,
    input  logic [OUT_BYTES-1:0][SW-1:0]   sel,
    output logic [OUT_BYTES*8-1:0]         dst
);
    for (genvar i = 0; i < OUT_BYTES; i++) begin : g_lane
        assign dst[i*8 +: 8] = src[sel[i]*8 +: 8];
    end
endmodule

// File: rtl/ilv_store_seq.sv
module ilv_store_seq
    import ilv_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned NREG       = 8,
    parameter int unsigned PORTS      = 4,
    parameter int unsigned BEAT_BYTES = 8,
    localparam int unsigned RAW = $clog2(NREG),
    localparam int unsigned WAW = $clog2(PORTS),
    localparam int unsigned SW  = $clog2(PORTS * 4)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           start,
    input  logic [1:0]                     part,
    input  logic                           four,
    input  logic [1:0]                     size,
    input  logic [RAW-1:0]                 qbase,
    input  logic [ADDR_W-1:0]              base,
    output logic                           valid,
    output logic [ADDR_W-1:0]              addr,
    output logic                           err,
    output logic [PORTS-1:0][RAW-1:0]      port_reg,
    output logic [PORTS-1:0][WAW-1:0]      port_word,
    output logic [BEAT_BYTES-1:0][SW-1:0]  xsel
);
    ilv_state_t state, state_nx;

    logic              c_four;
    logic [1:0]        c_part;
    logic [1:0]        c_size;
    logic [RAW-1:0]    c_qbase;
    logic [ADDR_W-5:0] c_blk;
    logic              err_q;
    logic              cmd_ok;
    logic              hi;

    assign cmd_ok = (base[3:0] == 4'd0) && (size != 2'd3) && (four || !part[1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start && cmd_ok) state_nx = ST_LO_BEAT;
            ST_LO_BEAT: state_nx = ST_HI_BEAT;
            ST_HI_BEAT: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_four  <= 1'b0;
            c_part  <= '0;
            c_size  <= '0;
            c_qbase <= '0;
            c_blk   <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= (state == ST_IDLE) && start && !cmd_ok;
            if (state == ST_IDLE && start && cmd_ok) begin
                c_four  <= four;
                c_part  <= part;
                c_size  <= size;
                c_qbase <= qbase;
                c_blk   <= base[ADDR_W-1:4] + {{(ADDR_W-6){1'b0}}, part};
            end
        end
    end

    always_comb begin
        valid = (state != ST_IDLE);
        hi    = (state == ST_HI_BEAT);
        err   = err_q;
        addr  = valid ? {c_blk, hi, 3'b000} : '0;
    end

    // byte mapping: stream byte -> register index (relative) and register byte
    logic [BEAT_BYTES-1:0][1:0] rel_reg;
    logic [BEAT_BYTES-1:0][3:0] reg_byte;

    always_comb begin
        logic [5:0] s;
        logic [5:0] k;
        logic [5:0] lane;
        logic [5:0] rb;
        logic [5:0] emask;
        emask = (6'd1 << c_size) - 6'd1;
        for (int i = 0; i < BEAT_BYTES; i++) begin
            s    = {c_part, hi, i[2:0]};
            k    = s >> c_size;
            lane = c_four ? (k >> 2) : (k >> 1);
            rb   = (lane << c_size) | (s & emask);
            rel_reg[i]  = c_four ? k[1:0] : {1'b0, k[0]};
            reg_byte[i] = rb[3:0];
            xsel[i]     = {rel_reg[i], rb[1:0]};
        end
    end

    always_comb begin
        for (int j = 0; j < PORTS; j++) begin
            port_word[j] = '0;
            for (int i = 0; i < BEAT_BYTES; i++) begin
                if (rel_reg[i] == j[1:0]) begin
                    port_word[j] = reg_byte[i][3:2];
                end
            end
        end
    end

    for (genvar j = 0; j < PORTS; j++) begin : g_preg
        assign port_reg[j] = c_qbase + RAW'(j);
    end

    // R3
    pair_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |=> valid);
    // R3
    pair_end_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && $past(valid)) |=> !valid);
    // R4
    lo_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !$past(valid)) |-> (addr[3:0] == 4'd0));
    // R4
    hi_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && $past(valid)) |-> (addr[3] && addr[ADDR_W-1:4] == $past(addr[ADDR_W-1:4])));
    // R8
    err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(err && valid));
    // R10
    busy_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        valid |=> !err);
endmodule

// File: rtl/ilv_store_unit.sv
module ilv_store_unit
    import ilv_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned NREG   = 8,
    parameter int unsigned VBITS  = 128,
    parameter int unsigned WBITS  = 32,
    localparam int unsigned WORDS      = VBITS / WBITS,
    localparam int unsigned RAW        = $clog2(NREG),
    localparam int unsigned WAW        = $clog2(WORDS),
    localparam int unsigned BEAT_BYTES = 8,
    localparam int unsigned SW         = $clog2(WORDS * WBITS / BYTE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_wr_idx,
    input  logic [127:0]      reg_wr_data,
    input  logic              st_start,
    input  logic [1:0]        st_part,
    input  logic              st_four,
    input  logic [1:0]        st_size,
    input  logic [2:0]        st_qbase,
    input  logic [31:0]       st_base,
    output logic              beat_valid,
    output logic [31:0]       beat_addr,
    output logic [63:0]       beat_data,
    output logic              st_err
);
    logic [WORDS-1:0][RAW-1:0]       port_reg;
    logic [WORDS-1:0][WAW-1:0]       port_word;
    logic [WORDS-1:0][WBITS-1:0]     port_data;
    logic [BEAT_BYTES-1:0][SW-1:0]   xsel;
    logic [BEAT_BYTES*8-1:0]         xout;

    ilv_regfile #(.NREG(NREG), .VBITS(VBITS), .WBITS(WBITS)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .wr_idx  (reg_wr_idx),
        .wr_data (reg_wr_data),
        .rd_reg  (port_reg),
        .rd_word (port_word),
        .rd_data (port_data)
    );

    ilv_store_seq #(.ADDR_W(ADDR_W), .NREG(NREG), .PORTS(WORDS), .BEAT_BYTES(BEAT_BYTES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (st_start),
        .part      (st_part),
        .four      (st_four),
        .size      (st_size),
        .qbase     (st_qbase),
        .base      (st_base),
        .valid     (beat_valid),
        .addr      (beat_addr),
        .err       (st_err),
        .port_reg  (port_reg),
        .port_word (port_word),
        .xsel      (xsel)
    );

    ilv_xbar #(.IN_BYTES(WORDS * WBITS / BYTE_W), .OUT_BYTES(BEAT_BYTES)) u_xbar (
        .src (port_data),
        .sel (xsel),
        .dst (xout)
    );

    assign beat_data = beat_valid ? xout : '0;

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !beat_valid |-> (beat_data == 64'd0 && beat_addr == 32'd0));
endmodule

// File: tb/ilv_store_unit_tb.sv
module ilv_store_unit_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_wr_en = 1'b0;
    logic [2:0]   reg_wr_idx = '0;
    logic [127:0] reg_wr_data = '0;
    logic         st_start = 1'b0;
    logic [1:0]   st_part = '0;
    logic         st_four = 1'b0;
    logic [1:0]   st_size = '0;
    logic [2:0]   st_qbase = '0;
    logic [31:0]  st_base = '0;
    logic         beat_valid;
    logic [31:0]  beat_addr;
    logic [63:0]  beat_data;
    logic         st_err;

    int total = 0;
    int bad   = 0;
    string ctx = "R1";

    always #5 clk = ~clk;

    ilv_store_unit u_dut (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data),
        .st_start(st_start), .st_part(st_part), .st_four(st_four), .st_size(st_size),
        .st_qbase(st_qbase), .st_base(st_base),
        .beat_valid(beat_valid), .beat_addr(beat_addr), .beat_data(beat_data), .st_err(st_err)
    );

    // behavioural reference model
    logic [7:0]  mir [8][16];
    logic        m_v = 1'b0;
    logic [31:0] m_a = '0;
    logic [63:0] m_d = '0;
    logic        m_e = 1'b0;
    logic [31:0] qa[$];
    logic [63:0] qd[$];

    function automatic logic [63:0] ref_beat(int p, int four, int sz, int qb, int hi);
        logic [63:0] res;
        int e, f, s, k, r, l, rb;
        e = 1 << sz;
        f = four ? 4 : 2;
        for (int i = 0; i < 8; i++) begin
            s  = p * 16 + hi * 8 + i;
            k  = s / e;
            r  = (qb + k % f) % 8;
            l  = k / f;
            rb = l * e + s % e;
            res[8*i +: 8] = mir[r][rb];
        end
        return res;
    endfunction

    always @(posedge clk) begin
        logic acc;
        logic ok;
        if (rst) begin
            for (int r = 0; r < 8; r++)
                for (int b = 0; b < 16; b++)
                    mir[r][b] = 8'h00;
            qa.delete();
            qd.delete();
            m_v = 0; m_a = 0; m_d = 0; m_e = 0;
        end else begin
            acc = st_start && !m_v;
            if (reg_wr_en)
                for (int b = 0; b < 16; b++)
                    mir[reg_wr_idx][b] = reg_wr_data[8*b +: 8];
            m_v = 0; m_a = 0; m_d = 0; m_e = 0;
            if (qa.size() > 0) begin
                m_v = 1;
                m_a = qa.pop_front();
                m_d = qd.pop_front();
            end else if (acc) begin
                ok = (st_base[3:0] == 0) && (st_size != 3) && (st_four || st_part < 2);
                if (!ok) begin
                    m_e = 1;
                end else begin
                    m_v = 1;
                    m_a = st_base + 32'(st_part) * 16;
                    m_d = ref_beat(st_part, st_four, st_size, st_qbase, 0);
                    qa.push_back(st_base + 32'(st_part) * 16 + 8);
                    qd.push_back(ref_beat(st_part, st_four, st_size, st_qbase, 1));
                end
            end
        end
    end

    task automatic check(logic cond, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s [%s] actual=%h expected=%h at %0t", what, ctx, act, exp, $time);
        end
    endtask

    // compare on every clock, away from the rising edge
    always @(negedge clk) begin
        if (!rst) begin
            check(beat_valid === m_v, "R3 R10 valid", 64'(beat_valid), 64'(m_v));
            check(beat_addr === m_a, "R4 addr", 64'(beat_addr), 64'(m_a));
            check(st_err === m_e, "R8 R9 err", 64'(st_err), 64'(m_e));
            if (m_v)
                check(beat_data === m_d, "data", beat_data, m_d);
            else
                check(beat_data === 64'd0, "R11 idle data", beat_data, 64'd0);
        end
    end

    task automatic wr_reg(int idx, logic [127:0] val);
        @(negedge clk);
        reg_wr_en = 1; reg_wr_idx = 3'(idx); reg_wr_data = val;
        @(negedge clk);
        reg_wr_en = 0;
    endtask

    task automatic store(int p, int four, int sz, int qb, logic [31:0] base);
        @(negedge clk);
        st_start = 1; st_part = 2'(p); st_four = four[0]; st_size = 2'(sz);
        st_qbase = 3'(qb); st_base = base;
        @(negedge clk);
        st_start = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic fill_random();
        for (int r = 0; r < 8; r++)
            wr_reg(r, {$urandom, $urandom, $urandom, $urandom});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check(beat_valid === 1'b0, "R1 reset valid", 64'(beat_valid), 64'd0);
        check(st_err === 1'b0, "R1 reset err", 64'(st_err), 64'd0);
        rst = 0;
        // R1: registers cleared, store reads zeros
        ctx = "R1";
        store(0, 1, 0, 0, 32'h100);

        // R2: write lands and is read by a store started in the same cycle
        ctx = "R2";
        fill_random();
        @(negedge clk);
        reg_wr_en = 1; reg_wr_idx = 3'd0; reg_wr_data = {4{32'hA5C3_0F1E}};
        st_start = 1; st_part = 0; st_four = 1; st_size = 2; st_qbase = 0; st_base = 32'h200;
        @(negedge clk);
        reg_wr_en = 0; st_start = 0;
        repeat (3) @(negedge clk);

        // R5 and R6: every factor, size and part with random contents and start register
        for (int rep = 0; rep < 3; rep++) begin
            for (int four = 0; four < 2; four++) begin
                for (int sz = 0; sz < 3; sz++) begin
                    for (int p = 0; p < (four ? 4 : 2); p++) begin
                        ctx = four ? "R5 four-way" : "R6 two-way";
                        fill_random();
                        store(p, four, sz, $urandom_range(0, 7), $urandom & 32'hFFFF_FFF0);
                    end
                end
            end
        end

        // R7: start register wraps past the top
        ctx = "R7 wrap";
        fill_random();
        store(3, 1, 0, 6, 32'h4000);
        store(1, 0, 1, 7, 32'h5000);
        store(2, 1, 2, 5, 32'h6000);

        // R8: misaligned base
        ctx = "R8 misaligned";
        store(0, 1, 0, 0, 32'h1008);
        store(1, 0, 2, 0, 32'h1001);

        // R9: bad size code and out-of-range part
        ctx = "R9 bad cmd";
        store(0, 1, 3, 0, 32'h2000);
        store(2, 0, 1, 0, 32'h2000);
        store(3, 0, 0, 0, 32'h2000);

        // R10: start held while busy, second command misaligned and ignored
        ctx = "R10 busy";
        fill_random();
        @(negedge clk);
        st_start = 1; st_part = 1; st_four = 1; st_size = 1; st_qbase = 2; st_base = 32'h3000;
        @(negedge clk);
        st_base = 32'h3004; st_part = 0;
        @(negedge clk);
        st_size = 3;
        @(negedge clk);
        st_start = 0;
        repeat (4) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog [%s] actual=%h expected=%h", ctx, 64'd1, 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule